// File: doc/BRIEF.md
# SIMD Branch Target Unit

This block resolves one 64-bit branch instruction for a 16-lane SIMD processor. It decides whether the branch is taken by reducing the per-lane A flags across the lanes with an any or all test. The lanes taking part can be narrowed by the per-lane multisample flags, either lane by lane or by 2x2 quad. It also computes the next instruction pointer and, when the instruction asks for it, a new uniform-stream pointer. Each pointer has its own source mode: an absolute address, an address relative to a base, the link register, or a register-file value.

The surrounding pipeline presents the instruction and its operands on one cycle. The results appear on registered outputs on the following cycle. The register-file read address is decoded straight from the instruction and driven out combinationally, so that the operand can be fetched. The fetch of the instruction and the register read itself happen outside this block.

Top module: `bt_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every registered output (`taken_o`, `err_o`, `unif_we_o`, `next_ip_o`, `next_unif_o`) becomes zero.
- R2: Outputs are registered with one cycle of latency. A word with bit 57 clear is not a branch and gives `taken_o`=0, `err_o`=0, `unif_we_o`=0, `next_ip_o` = current pointer + 8 and `next_unif_o` = current uniform pointer.
- R3: The immediate target is {insn[31:24], insn[55:35], 3'b000}. With instruction-pointer mode (bits 13:12) 0, a taken branch loads it as is.
- R4: Condition field bits 34:32 are decoded as follows. 0 means always. 2 means lane 0 A set and 3 means lane 0 A clear; both look at lane 0 whatever the masking. 4 means all active lanes have A set, 5 means some active lane has A clear, 6 means some active lane has A set, and 7 means all active lanes have A clear.
- R5: Condition code 1 is reserved. A branch carrying it sets `err_o`=1 and is not taken.
- R6: Multisample mode (bits 22:21) 1 keeps only the lanes whose multisample flag is set. Mode 0 keeps all lanes.
- R7: Multisample mode 2 drops a whole quad (lanes 4q..4q+3) when all four of its multisample flags are clear, and keeps the whole quad otherwise. Mode 3 behaves like mode 0.
- R8: With no active lanes left, conditions 4 and 7 are true and conditions 5 and 6 are false.
- R9: Instruction-pointer mode 1 gives current pointer + immediate, wrapping at 32 bits. Mode 2 gives the link value and mode 3 gives the register-file value. `rf_raddr_o` always equals insn[11:6].
- R10: With bit 14 set on a taken branch, uniform mode (bits 16:15; bit 17 has no effect) selects the new uniform pointer: 0 the loaded uniform, 1 current uniform pointer + loaded uniform (32-bit wrap), 2 the link value, 3 the register-file value. `unif_we_o` is then 1.
- R11: With bit 14 clear, or on a branch that is not taken, `unif_we_o`=0 and `next_uniform` equals the current uniform pointer.
- R12: A branch that is not taken gives `next_ip_o` = current pointer + 8, wrapping at 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_i | input | 64 | Instruction word |
| cur_ip_i | input | 32 | Address of this instruction |
| cur_unif_i | input | 32 | Current uniform-stream pointer |
| link_i | input | 32 | Link register value |
| rf_data_i | input | 32 | Register-file value read at `rf_raddr_o` |
| unif_data_i | input | 32 | Uniform value loaded with the instruction |
| flag_a_i | input | 16 | Per-lane A flags |
| msf_i | input | 16 | Per-lane multisample flags |
| rf_raddr_o | output | 6 | Register-file read address (combinational) |
| taken_o | output | 1 | Branch taken |
| next_ip_o | output | 32 | Next instruction pointer |
| next_unif_o | output | 32 | Next uniform pointer |
| unif_we_o | output | 1 | Uniform pointer update enable |
| err_o | output | 1 | Reserved condition seen |

## Verification
The assertions check the following on every cycle: a reserved-code error never comes with a taken branch and always traces back to a branch word carrying code 1, a non-branch word never yields taken or error, every not-taken result falls through to the previous pointer plus 8, and the uniform pointer only moves when its enable is up, which in turn needs a taken branch. Only the bench scenarios can show the things that depend on chosen stimulus. These are the lane and quad masking outcomes, the empty-set results of the any and all tests, the assembly of the split immediate, and the choice of source for each pointer, including 32-bit wraparound.

// File: rtl/bt_pkg.sv
// Package bt_pkg: shared widths, codes and the decoded-branch record for the
// branch target unit. Assumes a 64-bit instruction word and 32-bit pointers.
package bt_pkg;
    localparam int INSN_W = 64;
    localparam int PTR_W  = 32;
    localparam int RADR_W = 6;

    typedef enum logic [2:0] {
        CND_ALWAYS   = 3'd0,
        CND_RSVD     = 3'd1,
        CND_L0_SET   = 3'd2,
        CND_L0_CLR   = 3'd3,
        CND_ALL_SET  = 3'd4,
        CND_ANY_CLR  = 3'd5,
        CND_ANY_SET  = 3'd6,
        CND_ALL_CLR  = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        MSK_NONE = 2'd0,
        MSK_LANE = 2'd1,
        MSK_QUAD = 2'd2,
        MSK_RSVD = 2'd3
    } mask_e;

    typedef enum logic [1:0] {
        SRC_ABS  = 2'd0,
        SRC_REL  = 2'd1,
        SRC_LINK = 2'd2,
        SRC_RF   = 2'd3
    } src_e;

    typedef struct packed {
        logic              is_br;
        cond_e             cond;
        mask_e             mask;
        src_e              ip_src;
        src_e              un_src;
        logic              un_upd;
        logic [RADR_W-1:0] raddr;
        logic [PTR_W-1:0]  imm;
    } br_dec_t;
endpackage

// File: rtl/bt_decode.sv
// Module bt_decode: splits a branch word into its fields and assembles the
// immediate target. Purely combinational; assumes the field layout fixed by
// the instruction format (the positions are behaviour here).
module bt_decode
    import bt_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output br_dec_t           dec_o
);
    // Field extraction and immediate assembly.
    always_comb begin
        dec_o.is_br  = insn_i[57];
        dec_o.cond   = cond_e'(insn_i[34:32]);
        dec_o.mask   = mask_e'(insn_i[22:21]);
        dec_o.un_src = src_e'(insn_i[16:15]);
        dec_o.un_upd = insn_i[14];
        dec_o.ip_src = src_e'(insn_i[13:12]);
        dec_o.raddr  = insn_i[11:6];
        dec_o.imm    = {insn_i[31:24], insn_i[55:35], 3'b000};
    end
endmodule

// File: rtl/bt_cond_eval.sv
// Module bt_cond_eval: builds the active-lane set from the multisample mode
// and reduces the A flags over it. Assumes LANES is a multiple of 4 (quads).
module bt_cond_eval
    import bt_pkg::*;
#(
    parameter int LANES = 16
) (
    input  cond_e            cond_i,
    input  mask_e            mask_i,
    input  logic [LANES-1:0] flag_a_i,
    input  logic [LANES-1:0] msf_i,
    output logic             pass_o,
    output logic             rsvd_o
);
    localparam int QUADS = LANES / 4;

    logic [LANES-1:0] quad_act;
    logic [LANES-1:0] act;
    logic             any_set;
    logic             any_clr;

    // One quad-level activity bit spread over its four lanes.
    for (genvar q = 0; q < QUADS; q++) begin : g_quad
        assign quad_act[4*q +: 4] = {4{|msf_i[4*q +: 4]}};
    end

    // Active-lane mask per multisample mode.
    always_comb begin
        unique case (mask_i)
            MSK_LANE: act = msf_i;
            MSK_QUAD: act = quad_act;
            default:  act = '1;
        endcase
    end

    assign any_set = |(flag_a_i & act);
    assign any_clr = |(~flag_a_i & act);

    // Condition code to pass/fail; empty set gives all=true, any=false.
    always_comb begin
        rsvd_o = 1'b0;
        unique case (cond_i)
            CND_ALWAYS:  pass_o = 1'b1;
            CND_L0_SET:  pass_o = flag_a_i[0];
            CND_L0_CLR:  pass_o = ~flag_a_i[0];
            CND_ALL_SET: pass_o = ~any_clr;
            CND_ANY_CLR: pass_o = any_clr;
            CND_ANY_SET: pass_o = any_set;
            CND_ALL_CLR: pass_o = ~any_set;
            default: begin
                pass_o = 1'b0;
                rsvd_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bt_ptr_sel.sv
// Module bt_ptr_sel: picks a pointer from one of four sources. The relative
// source adds the absolute value to a base with modulo-2^W wraparound.
module bt_ptr_sel
    import bt_pkg::*;
#(
    parameter int W = 32
) (
    input  src_e         src_i,
    input  logic [W-1:0] abs_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] link_i,
    input  logic [W-1:0] rf_i,
    output logic [W-1:0] ptr_o
);
    // Source multiplexer.
    always_comb begin
        unique case (src_i)
            SRC_ABS:  ptr_o = abs_i;
            SRC_REL:  ptr_o = base_i + abs_i;
            SRC_LINK: ptr_o = link_i;
            default:  ptr_o = rf_i;
        endcase
    end
endmodule

// File: rtl/bt_unit.sv
// Module bt_unit: top of the branch target unit. Decodes a branch word,
// evaluates its cross-lane condition and registers the taken bit, both next
// pointers, the uniform enable and the reserved-code error. Assumes the
// caller presents instruction and operands together on one cycle.
module bt_unit
    import bt_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSN_W-1:0]   insn_i,
    input  logic [PTR_W-1:0]    cur_ip_i,
    input  logic [PTR_W-1:0]    cur_unif_i,
    input  logic [PTR_W-1:0]    link_i,
    input  logic [PTR_W-1:0]    rf_data_i,
    input  logic [PTR_W-1:0]    unif_data_i,
    input  logic [LANES-1:0]    flag_a_i,
    input  logic [LANES-1:0]    msf_i,
    output logic [RADR_W-1:0]   rf_raddr_o,
    output logic                taken_o,
    output logic [PTR_W-1:0]    next_ip_o,
    output logic [PTR_W-1:0]    next_unif_o,
    output logic                unif_we_o,
    output logic                err_o
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(8);

    br_dec_t          dec;
    logic             pass;
    logic             rsvd;
    logic             take_d;
    logic             we_d;
    logic [PTR_W-1:0] ip_tgt;
    logic [PTR_W-1:0] un_tgt;
    logic             prim_q;

    bt_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    bt_cond_eval #(.LANES(LANES)) u_cond (
        .cond_i   (dec.cond),
        .mask_i   (dec.mask),
        .flag_a_i (flag_a_i),
        .msf_i    (msf_i),
        .pass_o   (pass),
        .rsvd_o   (rsvd)
    );

    bt_ptr_sel #(.W(PTR_W)) u_ip_sel (
        .src_i  (dec.ip_src),
        .abs_i  (dec.imm),
        .base_i (cur_ip_i),
        .link_i (link_i),
        .rf_i   (rf_data_i),
        .ptr_o  (ip_tgt)
    );

    bt_ptr_sel #(.W(PTR_W)) u_un_sel (
        .src_i  (dec.un_src),
        .abs_i  (unif_data_i),
        .base_i (cur_unif_i),
        .link_i (link_i),
        .rf_i   (rf_data_i),
        .ptr_o  (un_tgt)
    );

    assign rf_raddr_o = dec.raddr;
    assign take_d     = dec.is_br & pass;
    assign we_d       = take_d & dec.un_upd;

    // Result registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o     <= 1'b0;
            err_o       <= 1'b0;
            unif_we_o   <= 1'b0;
            next_ip_o   <= '0;
            next_unif_o <= '0;
        end else begin
            taken_o     <= take_d;
            err_o       <= dec.is_br & rsvd;
            unif_we_o   <= we_d;
            next_ip_o   <= take_d ? ip_tgt : cur_ip_i + STEP;
            next_unif_o <= we_d ? un_tgt : cur_unif_i;
        end
    end

    // Marks that the result registers hold a computed value, not reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prim_q <= 1'b0;
        else        prim_q <= 1'b1;
    end

    // R5: a reserved-code error never accompanies a taken branch.
    a_r5_err_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !taken_o);

    // R5: an error traces back to a branch word carrying code 1.
    a_r5_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_q && err_o) |-> ($past(insn_i[57]) && $past(insn_i[34:32]) == 3'd1));

    // R2: a non-branch word yields neither taken nor error.
    a_r2_nonbranch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_q && !$past(insn_i[57])) |-> (!taken_o && !err_o));

    // R12: every not-taken result falls through by 8.
    a_r12_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_q && !taken_o) |-> next_ip_o == $past(cur_ip_i) + STEP);

    // R11: the uniform pointer holds while its enable is low.
    a_r11_unif_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_q && !unif_we_o) |-> next_unif_o == $past(cur_unif_i));

    // R10: a uniform update needs a taken branch.
    a_r10_we_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
        unif_we_o |-> taken_o);
endmodule

// File: tb/bt_unit_bench.sv
// Directed bench for bt_unit: one task per scenario, each checking its own
// results against a behavioural model written from the requirements.
module bt_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] insn = '0;
    logic [31:0] cur_ip = '0, cur_unif = '0, link = '0, rf_data = '0, unif_data = '0;
    logic [15:0] flag_a = '0, msf = '0;
    logic [5:0]  rf_raddr;
    logic        taken, unif_we, err;
    logic [31:0] next_ip, next_unif;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    bt_unit u_bt_unit (
        .clk(clk), .rst_n(rst_n), .insn_i(insn), .cur_ip_i(cur_ip),
        .cur_unif_i(cur_unif), .link_i(link), .rf_data_i(rf_data),
        .unif_data_i(unif_data), .flag_a_i(flag_a), .msf_i(msf),
        .rf_raddr_o(rf_raddr), .taken_o(taken), .next_ip_o(next_ip),
        .next_unif_o(next_unif), .unif_we_o(unif_we), .err_o(err)
    );

    always #4 clk = ~clk;

    // Watchdog: counts cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [63:0] mk_br(input logic [2:0] cnd, input logic [1:0] mm,
                                          input logic [1:0] ips, input logic ub,
                                          input logic [2:0] uns, input logic [31:0] adr,
                                          input logic [5:0] ra);
        logic [63:0] w;
        w = '0;
        w[57] = 1'b1;
        w[55:35] = adr[23:3];
        w[34:32] = cnd;
        w[31:24] = adr[31:24];
        w[22:21] = mm;
        w[17:15] = uns;
        w[14] = ub;
        w[13:12] = ips;
        w[11:6] = ra;
        return w;
    endfunction

    // Behavioural model of all registered outputs from the current inputs.
    task automatic model(output logic e_tk, output logic e_er, output logic e_we,
                         output logic [31:0] e_ip, output logic [31:0] e_un);
        logic act;
        int n_set, n_clr;
        logic pass;
        logic [31:0] imm, t_ip, t_un;
        n_set = 0; n_clr = 0;
        for (int i = 0; i < 16; i++) begin
            case (insn[22:21])
                2'd1: act = msf[i];
                2'd2: act = msf[(i/4)*4] | msf[(i/4)*4+1] | msf[(i/4)*4+2] | msf[(i/4)*4+3];
                default: act = 1'b1;
            endcase
            if (act && flag_a[i]) n_set++;
            if (act && !flag_a[i]) n_clr++;
        end
        case (insn[34:32])
            3'd0: pass = 1'b1;
            3'd1: pass = 1'b0;
            3'd2: pass = flag_a[0];
            3'd3: pass = !flag_a[0];
            3'd4: pass = (n_clr == 0);
            3'd5: pass = (n_clr != 0);
            3'd6: pass = (n_set != 0);
            default: pass = (n_set == 0);
        endcase
        imm = {insn[31:24], insn[55:35], 3'b000};
        case (insn[13:12])
            2'd0: t_ip = imm;
            2'd1: t_ip = cur_ip + imm;
            2'd2: t_ip = link;
            default: t_ip = rf_data;
        endcase
        case (insn[16:15])
            2'd0: t_un = unif_data;
            2'd1: t_un = cur_unif + unif_data;
            2'd2: t_un = link;
            default: t_un = rf_data;
        endcase
        e_tk = insn[57] && pass;
        e_er = insn[57] && (insn[34:32] == 3'd1);
        e_we = e_tk && insn[14];
        e_ip = e_tk ? t_ip : cur_ip + 32'd8;
        e_un = e_we ? t_un : cur_unif;
    endtask

    // Applies the driven inputs for one edge and compares every output.
    task automatic go(input string tag);
        logic e_tk, e_er, e_we;
        logic [31:0] e_ip, e_un;
        model(e_tk, e_er, e_we, e_ip, e_un);
        @(negedge clk);
        checks++;
        if (taken !== e_tk || err !== e_er || unif_we !== e_we ||
            next_ip !== e_ip || next_unif !== e_un) begin
            failures++;
            $display("FAIL %s: actual tk=%b er=%b we=%b ip=%h un=%h expected tk=%b er=%b we=%b ip=%h un=%h",
                     tag, taken, err, unif_we, next_ip, next_unif, e_tk, e_er, e_we, e_ip, e_un);
        end
    endtask

    // Checks one expected taken value explicitly besides the model.
    task automatic want_taken(input string tag, input logic exp);
        checks++;
        if (taken !== exp) begin
            failures++;
            $display("FAIL %s: actual taken=%b expected=%b", tag, taken, exp);
        end
    endtask

    task automatic t_reset();
        insn = mk_br(3'd0, 2'd0, 2'd2, 1'b1, 3'd2, 32'h1234_5678, 6'd0);
        link = 32'hDEAD_BEE0; cur_ip = 32'h40;
        @(negedge clk); @(negedge clk);
        checks++;
        if (taken !== 1'b0 || err !== 1'b0 || unif_we !== 1'b0 ||
            next_ip !== 32'h0 || next_unif !== 32'h0) begin
            failures++;
            $display("FAIL R1: actual tk=%b er=%b we=%b ip=%h un=%h expected all zero",
                     taken, err, unif_we, next_ip, next_unif);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_nonbranch();
        insn = mk_br(3'd0, 2'd0, 2'd2, 1'b1, 3'd2, 32'hFFFF_FFF8, 6'd5);
        insn[57] = 1'b0;
        cur_ip = 32'h0000_1000; cur_unif = 32'h0000_2000;
        go("R2 non-branch");
        want_taken("R2 non-branch taken", 1'b0);
    endtask

    task automatic t_abs();
        cur_ip = 32'h0000_0100;
        insn = mk_br(3'd0, 2'd0, 2'd0, 1'b0, 3'd0, 32'hA5C3_7F18, 6'd0);
        go("R3 absolute");
        checks++;
        if (next_ip !== 32'hA5C3_7F18) begin
            failures++;
            $display("FAIL R3: actual ip=%h expected=%h", next_ip, 32'hA5C3_7F18);
        end
    endtask

    task automatic t_conds();
        logic [15:0] pats [5] = '{16'hFFFF, 16'h0000, 16'h0001, 16'hFFFE, 16'h5A3C};
        cur_ip = 32'h0000_0800;
        msf = '0;
        for (int p = 0; p < 5; p++) begin
            for (int c = 0; c < 8; c++) begin
                if (c == 1) continue;
                flag_a = pats[p];
                insn = mk_br(3'(c), 2'd0, 2'd0, 1'b0, 3'd0, 32'h0000_4000, 6'd0);
                go("R4 condition");
            end
        end
        flag_a = 16'h5A3C;
        insn = mk_br(3'd4, 2'd0, 2'd0, 1'b0, 3'd0, 32'h0000_4000, 6'd0);
        go("R4 all-set mixed");
        want_taken("R4 all-set mixed", 1'b0);
        insn = mk_br(3'd6, 2'd0, 2'd0, 1'b0, 3'd0, 32'h0000_4000, 6'd0);
        go("R4 any-set mixed");
        want_taken("R4 any-set mixed", 1'b1);
    endtask

    task automatic t_reserved();
        flag_a = 16'hFFFF;
        insn = mk_br(3'd1, 2'd0, 2'd0, 1'b1, 3'd0, 32'h0000_4000, 6'd0);
        go("R5 reserved");
        checks++;
        if (err !== 1'b1 || taken !== 1'b0) begin
            failures++;
            $display("FAIL R5: actual err=%b tk=%b expected err=1 tk=0", err, taken);
        end
    endtask

    task automatic t_msf_lane();
        flag_a = 16'h00FF; msf = 16'h000F;
        insn = mk_br(3'd4, 2'd1, 2'd0, 1'b0, 3'd0, 32'h0000_3000, 6'd0);
        go("R6 lane mask");
        want_taken("R6 lane mask all-set", 1'b1);
        insn = mk_br(3'd4, 2'd0, 2'd0, 1'b0, 3'd0, 32'h0000_3000, 6'd0);
        go("R6 no mask");
        want_taken("R6 no mask all-set", 1'b0);
        flag_a = 16'h0100; msf = 16'h00FF;
        insn = mk_br(3'd6, 2'd1, 2'd0, 1'b0, 3'd0, 32'h0000_3000, 6'd0);
        go("R6 lane mask any-set");
        want_taken("R6 lane mask any-set", 1'b0);
    endtask

    task automatic t_msf_quad();
        msf = 16'h0001; flag_a = 16'h000F;
        insn = mk_br(3'd4, 2'd2, 2'd0, 1'b0, 3'd0, 32'h0000_5000, 6'd0);
        go("R7 quad kept");
        want_taken("R7 quad all-set", 1'b1);
        flag_a = 16'h0007;
        go("R7 quad lane3 clear");
        want_taken("R7 quad lane3 clear", 1'b0);
        flag_a = 16'h000F;
        insn = mk_br(3'd4, 2'd3, 2'd0, 1'b0, 3'd0, 32'h0000_5000, 6'd0);
        go("R7 mode3 as none");
        want_taken("R7 mode3 as none", 1'b0);
    endtask

    task automatic t_empty();
        msf = 16'h0000; flag_a = 16'h0F0F;
        for (int c = 4; c < 8; c++) begin
            insn = mk_br(3'(c), 2'd1, 2'd0, 1'b0, 3'd0, 32'h0000_6000, 6'd0);
            go("R8 empty set");
            want_taken("R8 empty set", (c == 4 || c == 7));
        end
        insn = mk_br(3'd5, 2'd2, 2'd0, 1'b0, 3'd0, 32'h0000_6000, 6'd0);
        go("R8 empty quads");
        want_taken("R8 empty quads any-clear", 1'b0);
    endtask

    task automatic t_ip_modes();
        msf = '0; flag_a = '0;
        cur_ip = 32'hFFFF_FF00; link = 32'h0000_ABC0; rf_data = 32'h1357_9BD8;
        insn = mk_br(3'd0, 2'd0, 2'd1, 1'b0, 3'd0, 32'h0000_0200, 6'd0);
        go("R9 relative wrap");
        checks++;
        if (next_ip !== 32'h0000_0100) begin
            failures++;
            $display("FAIL R9: actual ip=%h expected=%h", next_ip, 32'h0000_0100);
        end
        insn = mk_br(3'd0, 2'd0, 2'd2, 1'b0, 3'd0, 32'h0000_0200, 6'd0);
        go("R9 link");
        insn = mk_br(3'd0, 2'd0, 2'd3, 1'b0, 3'd0, 32'h0000_0200, 6'd42);
        #1;
        checks++;
        if (rf_raddr !== 6'd42) begin
            failures++;
            $display("FAIL R9: actual raddr=%0d expected=42", rf_raddr);
        end
        go("R9 register file");
    endtask

    task automatic t_unif();
        cur_ip = 32'h0000_0040; cur_unif = 32'hFFFF_FFF0; unif_data = 32'h0000_0020;
        link = 32'h0000_7700; rf_data = 32'h0000_8800;
        for (int m = 0; m < 4; m++) begin
            insn = mk_br(3'd0, 2'd0, 2'd0, 1'b1, 3'(m), 32'h0000_0400, 6'd3);
            go("R10 uniform mode");
        end
        insn = mk_br(3'd0, 2'd0, 2'd0, 1'b1, 3'd5, 32'h0000_0400, 6'd3);
        go("R10 uniform bit17 ignored");
        checks++;
        if (next_unif !== 32'h0000_0010 || unif_we !== 1'b1) begin
            failures++;
            $display("FAIL R10: actual un=%h we=%b expected un=00000010 we=1", next_unif, unif_we);
        end
    endtask

    task automatic t_unif_off();
        cur_unif = 32'h0000_9000; unif_data = 32'h0000_0100;
        insn = mk_br(3'd0, 2'd0, 2'd0, 1'b0, 3'd0, 32'h0000_0400, 6'd0);
        go("R11 update bit clear");
        flag_a = 16'h0000;
        insn = mk_br(3'd2, 2'd0, 2'd0, 1'b1, 3'd0, 32'h0000_0400, 6'd0);
        go("R11 not taken");
        checks++;
        if (unif_we !== 1'b0 || next_unif !== 32'h0000_9000) begin
            failures++;
            $display("FAIL R11: actual we=%b un=%h expected we=0 un=00009000", unif_we, next_unif);
        end
    endtask

    task automatic t_fall();
        flag_a = 16'h0000; cur_ip = 32'hFFFF_FFF8;
        insn = mk_br(3'd2, 2'd0, 2'd0, 1'b0, 3'd0, 32'h0000_0400, 6'd0);
        go("R12 fall-through wrap");
        checks++;
        if (next_ip !== 32'h0000_0000) begin
            failures++;
            $display("FAIL R12: actual ip=%h expected=00000000", next_ip);
        end
    endtask

    initial begin
        t_reset();
        t_nonbranch();
        t_abs();
        t_conds();
        t_reserved();
        t_msf_lane();
        t_msf_quad();
        t_empty();
        t_ip_modes();
        t_unif();
        t_unif_off();
        t_fall();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule